// File: doc/BRIEF.md
# Range-Matched Translation Buffer with Block Slots

This block is a fully associative address translation buffer. Each entry holds an inclusive virtual window (a begin and an end address), a physical base and a 30-bit access word. A lookup compares the address against every window in parallel, in the same cycle. On a hit it returns the physical base, the window begin and the access word of the winning entry. Permission evaluation is left to a separate checker downstream.

The slots fall into two groups. The lowest `N_BLK` slots hold block entries, which can span many pages. They are written only through a command port that answers each command with a status word. The remaining slots hold single-page entries. These are installed in two steps: an insert-address operation places the window and physical base, and a later insert-protection operation loads the access word and validates the entry. When no existing page slot covers the address, a replacement pointer picks the victim slot. Single-page operations also include purge by address and purge of all page slots.

Every update, from either port, takes effect at the next rising clock edge.

Top module: `range_tlb`

## Requirements
- R1: An entry matches when begin <= address <= end, with both bounds inclusive. When several entries match, the lowest-indexed one wins. A block entry therefore overrides any page entry it overlaps.
- R2: After reset no address hits. Whenever `lk_hit` is 0, `lk_pbase`, `lk_vbegin` and `lk_access` are all zero.
- R3: Insert-address (`op_code` 0) writes the following:
  - the window begin as the address with its low 12 bits cleared;
  - the window end as begin + 4095;
  - the physical base as `op_data[24:5]` shifted left by 12.
  The entry stays invalid, so lookups in the window miss until protection is loaded.
- R4: Insert-protection (`op_code` 1) loads `op_data[29:1]` into `lk_access[29:1]` of the lowest-indexed matching entry and validates that entry. `lk_access[0]` reads 0. The access word carries:
  - an 18-bit id in [18:1];
  - a U flag in bit 19;
  - two 2-bit privilege fields in [21:20] and [23:22];
  - a 3-bit type in [26:24];
  - B, D and T flags in bits 27, 28 and 29.
  If no entry matches, the operation has no effect.
- R5: Insert-address scans only the page slots. It invalidates every valid page entry whose window covers the address and reuses the lowest covering slot. In that case the replacement pointer does not move.
- R6: When no page slot covers the address, the slot is taken from the replacement pointer. If the pointer is below `N_BLK` or at least `N_SLOT`, slot `N_BLK` is used and the pointer becomes `N_BLK`+1. Otherwise the slot at the pointer is used and the pointer increments. The pointer resets to `N_BLK`.
- R7: Purge by address (`op_code` 2) invalidates the lowest-indexed matching entry if it is a valid page entry. A block entry that matches is left intact.
- R8: Purge-all (`op_code` 3) invalidates every page slot and resets the pointer to `N_BLK`. Block slots are kept.
- R9: Block insert (`blk_code` 1) with `blk_slot` < `N_BLK` writes the slot as follows:
  - begin = `blk_vpage`<<12;
  - end = begin + `blk_len`*4096 - 1;
  - physical base = `blk_ppage`<<12;
  - access = `blk_prot` with bit 29 forced to 0 and bit 28 forced to 1;
  - the entry is valid.
  The status is 0.
- R10: Block insert or single purge with `blk_slot` >= `N_BLK` returns status 0xFFFFFFF6 (-10) and changes nothing. A `blk_code` above 3 returns 0xFFFFFFFE (-2).
- R11: `blk_code` 2 invalidates one block slot and `blk_code` 3 invalidates all block slots. Both return status 0.
- R12: `blk_code` 0 returns status 0 and fills `blk_info` with four words, low to high: 1, 16384, `FIXED_BLK`, and `N_BLK`-`FIXED_BLK`. Every other command leaves `blk_info` at zero.
- R13: `blk_done` is high for exactly the cycle after `blk_valid`. If `op_valid` and `blk_valid` are high in the same cycle, only the block command executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_pbase | output | 32 | Physical base of the matched entry |
| lk_vbegin | output | 32 | Window begin of the matched entry |
| lk_access | output | 30 | Access word of the matched entry |
| op_valid | input | 1 | Page operation strobe |
| op_code | input | 2 | 0 insert-address, 1 insert-protection, 2 purge, 3 purge-all |
| op_addr | input | 32 | Operation virtual address |
| op_data | input | 32 | Operation operand |
| blk_valid | input | 1 | Block command strobe |
| blk_code | input | 32 | Block command code |
| blk_vpage | input | 20 | Block virtual page number |
| blk_ppage | input | 20 | Block physical page number |
| blk_len | input | 20 | Block length in pages |
| blk_slot | input | 32 | Block slot number |
| blk_prot | input | 32 | Block access word |
| blk_done | output | 1 | Command completed, status valid |
| blk_status | output | 32 | Command status |
| blk_info | output | 128 | Info words, first word in the low bits |

## Verification
The following are checked on every cycle by the bound assertions:
- miss outputs being zero;
- a hit never reporting a window begin above the address;
- the one-cycle done pulse;
- the status codes for bad slots and unknown commands;
- the constant info words.

The remaining behaviours only show up across a sequence of operations, so only the bench scenarios can reveal them:
- which slot the replacement pointer evicts;
- the reuse of a covering slot;
- block entries surviving page purges;
- the two-step validation of page entries.

// File: rtl/range_tlb.sv
module range_tlb #(
  parameter int N_SLOT    = 8,
  parameter int N_BLK     = 2,
  parameter int AW        = 32,
  parameter int PG_BITS   = 12,
  parameter int FIXED_BLK = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     lk_addr,
  output logic              lk_hit,
  output logic [AW-1:0]     lk_pbase,
  output logic [AW-1:0]     lk_vbegin,
  output logic [29:0]       lk_access,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [AW-1:0]     op_addr,
  input  logic [31:0]       op_data,
  input  logic              blk_valid,
  input  logic [31:0]       blk_code,
  input  logic [AW-PG_BITS-1:0] blk_vpage,
  input  logic [AW-PG_BITS-1:0] blk_ppage,
  input  logic [AW-PG_BITS-1:0] blk_len,
  input  logic [31:0]       blk_slot,
  input  logic [31:0]       blk_prot,
  output logic              blk_done,
  output logic [31:0]       blk_status,
  output logic [127:0]      blk_info
);
  localparam int SW   = $clog2(N_SLOT);
  localparam int PTRW = $clog2(N_SLOT + 1);
  localparam logic [31:0] ST_OK     = 32'h0000_0000;
  localparam logic [31:0] ST_BADARG = 32'hFFFF_FFF6;
  localparam logic [31:0] ST_BADOP  = 32'hFFFF_FFFE;
  localparam logic [1:0] OP_IADDR = 2'd0;
  localparam logic [1:0] OP_IPROT = 2'd1;
  localparam logic [1:0] OP_PURGE = 2'd2;
  localparam logic [1:0] OP_PALL  = 2'd3;

  logic [AW-1:0]     vb  [N_SLOT];
  logic [AW-1:0]     ve  [N_SLOT];
  logic [AW-1:0]     pa  [N_SLOT];
  logic [29:0]       acc [N_SLOT];
  logic [N_SLOT-1:0] vld;
  logic [PTRW-1:0]   ptr;

  logic              lk_found, op_found, cov_found;
  logic [SW-1:0]     lk_idx, op_idx, cov_idx;
  logic [N_SLOT-1:0] cov, kill;

  function automatic logic covers(input logic [AW-1:0] b, input logic [AW-1:0] e,
                                  input logic [AW-1:0] a);
    return (b <= a) && (a <= e);
  endfunction

  always_comb begin
    lk_found = 1'b0; lk_idx = '0;
    op_found = 1'b0; op_idx = '0;
    cov_found = 1'b0; cov_idx = '0; cov = '0;
    for (int i = N_SLOT - 1; i >= 0; i--) begin
      if (covers(vb[i], ve[i], lk_addr)) begin
        lk_found = 1'b1;
        lk_idx   = SW'(i);
      end
      if (covers(vb[i], ve[i], op_addr)) begin
        op_found = 1'b1;
        op_idx   = SW'(i);
        if (i >= N_BLK) begin
          cov[i]    = 1'b1;
          cov_found = 1'b1;
          cov_idx   = SW'(i);
        end
      end
    end
  end

  assign lk_hit    = lk_found && vld[lk_idx];
  assign lk_pbase  = lk_hit ? pa[lk_idx]  : '0;
  assign lk_vbegin = lk_hit ? vb[lk_idx]  : '0;
  assign lk_access = lk_hit ? acc[lk_idx] : '0;

  wire              alloc_wrap = (ptr < PTRW'(N_BLK)) || (ptr >= PTRW'(N_SLOT));
  wire [SW-1:0]     alloc_idx  = alloc_wrap ? SW'(N_BLK) : ptr[SW-1:0];
  wire [PTRW-1:0]   ptr_next   = alloc_wrap ? PTRW'(N_BLK + 1) : ptr + PTRW'(1);
  wire [SW-1:0]     ins_idx    = cov_found ? cov_idx : alloc_idx;

  wire              slot_ok = blk_slot < 32'(N_BLK);
  wire [SW-1:0]     bslot   = blk_slot[SW-1:0];
  wire [AW-1:0]     bbegin  = {blk_vpage, {PG_BITS{1'b0}}};
  wire [AW-1:0]     bspan   = {blk_len, {PG_BITS{1'b0}}};
  wire              unused_bits = ^{op_data[31:30], op_data[0], blk_prot[31:28], blk_prot[0]};

  always_comb begin
    kill = '0;
    if (blk_valid) begin
      if ((blk_code == 32'd1 || blk_code == 32'd2) && slot_ok) kill[bslot] = 1'b1;
      if (blk_code == 32'd3)
        for (int i = 0; i < N_BLK; i++) kill[i] = 1'b1;
    end else if (op_valid) begin
      case (op_code)
        OP_IADDR: begin
          kill = cov & vld;
          if (!cov_found) kill[alloc_idx] = 1'b1;
        end
        OP_PURGE:
          if (op_found && vld[op_idx] && op_idx >= SW'(N_BLK)) kill[op_idx] = 1'b1;
        OP_PALL:
          for (int i = N_BLK; i < N_SLOT; i++) kill[i] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SLOT; i++) begin
        vb[i]  <= '1;
        ve[i]  <= '0;
        pa[i]  <= '0;
        acc[i] <= '0;
      end
      vld        <= '0;
      ptr        <= PTRW'(N_BLK);
      blk_done   <= 1'b0;
      blk_status <= ST_OK;
      blk_info   <= '0;
    end else begin
      blk_done <= blk_valid;
      for (int i = 0; i < N_SLOT; i++) begin
        if (kill[i]) begin
          vb[i]  <= '1;
          ve[i]  <= '0;
          pa[i]  <= '0;
          acc[i] <= '0;
          vld[i] <= 1'b0;
        end
      end
      if (blk_valid) begin
        blk_info   <= '0;
        blk_status <= ST_OK;
        case (blk_code)
          32'd0: blk_info <= {32'(N_BLK - FIXED_BLK), 32'(FIXED_BLK), 32'd16384, 32'd1};
          32'd1:
            if (slot_ok) begin
              vb[bslot]  <= bbegin;
              ve[bslot]  <= bbegin + bspan - AW'(1);
              pa[bslot]  <= {blk_ppage, {PG_BITS{1'b0}}};
              acc[bslot] <= {1'b0, 1'b1, blk_prot[27:1], 1'b0};
              vld[bslot] <= 1'b1;
            end else blk_status <= ST_BADARG;
          32'd2: if (!slot_ok) blk_status <= ST_BADARG;
          32'd3: ;
          default: blk_status <= ST_BADOP;
        endcase
      end else if (op_valid) begin
        case (op_code)
          OP_IADDR: begin
            vb[ins_idx] <= {op_addr[AW-1:PG_BITS], {PG_BITS{1'b0}}};
            ve[ins_idx] <= {op_addr[AW-1:PG_BITS], {PG_BITS{1'b1}}};
            pa[ins_idx] <= AW'({op_data[24:5], {PG_BITS{1'b0}}});
            if (!cov_found) ptr <= ptr_next;
          end
          OP_IPROT:
            if (op_found) begin
              acc[op_idx] <= {op_data[29:1], 1'b0};
              vld[op_idx] <= 1'b1;
            end
          OP_PALL: ptr <= PTRW'(N_BLK);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/range_tlb_chk.sv
module range_tlb_chk #(
  parameter int N_BLK = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic [31:0]  lk_addr,
  input logic         lk_hit,
  input logic [31:0]  lk_pbase,
  input logic [31:0]  lk_vbegin,
  input logic [29:0]  lk_access,
  input logic         blk_valid,
  input logic [31:0]  blk_code,
  input logic [31:0]  blk_slot,
  input logic         blk_done,
  input logic [31:0]  blk_status,
  input logic [127:0] blk_info
);
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pbase == 32'd0 && lk_vbegin == 32'd0 && lk_access == 30'd0));

  p_hit_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_vbegin <= lk_addr));

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |=> blk_done);

  p_no_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_valid |=> !blk_done);

  p_bad_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_code > 32'd3) |=> (blk_status == 32'hFFFF_FFFE));

  p_bad_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && (blk_code == 32'd1 || blk_code == 32'd2) && blk_slot >= 32'(N_BLK))
      |=> (blk_status == 32'hFFFF_FFF6));

  p_info_words_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_code == 32'd0) |=> (blk_info[63:0] == {32'd16384, 32'd1} && blk_status == 32'd0));

  p_info_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_code != 32'd0) |=> (blk_info == 128'd0));
endmodule

bind range_tlb range_tlb_chk #(.N_BLK(N_BLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(lk_hit),
  .lk_pbase(lk_pbase), .lk_vbegin(lk_vbegin), .lk_access(lk_access),
  .blk_valid(blk_valid), .blk_code(blk_code), .blk_slot(blk_slot),
  .blk_done(blk_done), .blk_status(blk_status), .blk_info(blk_info)
);

// File: tb/sim_range_tlb.sv
module sim_range_tlb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BADARG = 32'hFFFF_FFF6;
  localparam logic [31:0] BADOP  = 32'hFFFF_FFFE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] lk_addr = '0;
  logic lk_hit;
  logic [31:0] lk_pbase, lk_vbegin;
  logic [29:0] lk_access;
  logic op_valid = 1'b0;
  logic [1:0] op_code = '0;
  logic [31:0] op_addr = '0, op_data = '0;
  logic blk_valid = 1'b0;
  logic [31:0] blk_code = '0, blk_slot = '0, blk_prot = '0;
  logic [19:0] blk_vpage = '0, blk_ppage = '0, blk_len = '0;
  logic blk_done;
  logic [31:0] blk_status;
  logic [127:0] blk_info;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  range_tlb u0 (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_pbase(lk_pbase), .lk_vbegin(lk_vbegin), .lk_access(lk_access),
    .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr), .op_data(op_data),
    .blk_valid(blk_valid), .blk_code(blk_code), .blk_vpage(blk_vpage),
    .blk_ppage(blk_ppage), .blk_len(blk_len), .blk_slot(blk_slot),
    .blk_prot(blk_prot), .blk_done(blk_done), .blk_status(blk_status),
    .blk_info(blk_info)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(input string req, input logic [31:0] a, input logic hit,
                      input logic [31:0] pb, input logic [31:0] vbeg, input logic [29:0] ac);
    lk_addr = a;
    #1;
    if (hit) check(req, {lk_hit, lk_pbase, lk_vbegin, lk_access}, {1'b1, pb, vbeg, ac});
    else     check(req, {lk_hit, lk_pbase, lk_vbegin, lk_access}, '0);
  endtask

  task automatic op(input logic [1:0] c, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_addr = a; op_data = d;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic map_page(input logic [31:0] a, input logic [19:0] pp, input logic [31:0] prot);
    op(2'd0, a, {7'd0, pp, 5'd0});
    op(2'd1, a, prot);
  endtask

  task automatic blk(input string req, input logic [31:0] code, input logic [19:0] vp,
                     input logic [19:0] pp, input logic [19:0] len, input logic [31:0] slot,
                     input logic [31:0] prot, input logic [31:0] exp_status);
    @(negedge clk);
    blk_valid = 1'b1; blk_code = code; blk_vpage = vp; blk_ppage = pp;
    blk_len = len; blk_slot = slot; blk_prot = prot;
    @(negedge clk);
    blk_valid = 1'b0;
    check(req, {blk_done, blk_status}, {1'b1, exp_status});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] pp_word;
    pp_word = 32'h2AAA_5555;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 8; k++) look("R2 reset miss", 32'h1357_0000 * k + 32'h0000_0100, 0, 0, 0, 0);
    check("R13 done idle", {127'd0, blk_done}, 128'd0);

    op(2'd0, 32'h0001_2345, {7'd0, 20'h00ABC, 5'd0});
    look("R3 invalid until protected", 32'h0001_2345, 0, 0, 0, 0);
    op(2'd1, 32'h0001_2345, pp_word);
    look("R3 R4 hit begin", 32'h0001_2000, 1, 32'h00AB_C000, 32'h0001_2000, 30'h2AAA_5554);
    look("R1 hit end inclusive", 32'h0001_2FFF, 1, 32'h00AB_C000, 32'h0001_2000, 30'h2AAA_5554);
    look("R1 miss above end", 32'h0001_3000, 0, 0, 0, 0);
    look("R1 miss below begin", 32'h0001_1FFF, 0, 0, 0, 0);

    op(2'd1, 32'h0050_0000, pp_word);
    look("R4 protect without entry ignored", 32'h0050_0000, 0, 0, 0, 0);

    op(2'd0, 32'h0001_2800, {7'd0, 20'h00111, 5'd0});
    look("R5 covering entry flushed", 32'h0001_2000, 0, 0, 0, 0);
    op(2'd1, 32'h0001_2800, 32'h0000_0002);
    look("R5 reused slot", 32'h0001_2ABC, 1, 32'h0011_1000, 32'h0001_2000, 30'h0000_0002);

    for (int k = 0; k < 6; k++) map_page(32'h0010_0000 + (k << 12), 20'h00200 + k, pp_word);
    look("R6 wrap evicts first page slot", 32'h0001_2000, 0, 0, 0, 0);
    for (int k = 0; k < 6; k++)
      look("R6 fill", 32'h0010_0000 + (k << 12) + 32'h44, 1, (32'h200 + k) << 12,
           32'h0010_0000 + (k << 12), 30'h2AAA_5554);
    map_page(32'h0010_6000, 20'h00206, pp_word);
    look("R6 pointer after wrap", 32'h0010_0000, 0, 0, 0, 0);
    for (int k = 1; k < 7; k++)
      look("R6 survivors", 32'h0010_0000 + (k << 12), 1, (32'h200 + k) << 12,
           32'h0010_0000 + (k << 12), 30'h2AAA_5554);

    op(2'd2, 32'h0010_3123, 32'd0);
    look("R7 purged page", 32'h0010_3000, 0, 0, 0, 0);
    look("R7 neighbour kept", 32'h0010_4000, 1, 32'h0020_4000, 32'h0010_4000, 30'h2AAA_5554);

    blk("R9 insert status", 32'd1, 20'h00100, 20'h80000, 20'd4, 32'd0, 32'h3FFF_FFFF, 32'd0);
    look("R9 R1 block wins", 32'h0010_1000, 1, 32'h8000_0000, 32'h0010_0000, 30'h1FFF_FFFE);
    look("R9 block end", 32'h0010_3FFF, 1, 32'h8000_0000, 32'h0010_0000, 30'h1FFF_FFFE);
    look("R1 past block", 32'h0010_4000, 1, 32'h0020_4000, 32'h0010_4000, 30'h2AAA_5554);
    check("R12 info clear", blk_info, 128'd0);

    op(2'd2, 32'h0010_1000, 32'd0);
    look("R7 block untouched by purge", 32'h0010_1000, 1, 32'h8000_0000, 32'h0010_0000, 30'h1FFF_FFFE);

    op(2'd3, 32'd0, 32'd0);
    for (int k = 4; k < 7; k++) look("R8 pages cleared", 32'h0010_0000 + (k << 12), 0, 0, 0, 0);
    look("R8 block kept", 32'h0010_2000, 1, 32'h8000_0000, 32'h0010_0000, 30'h1FFF_FFFE);

    blk("R10 slot at limit", 32'd1, 20'h00500, 20'h1, 20'd1, 32'd2, 32'd0, BADARG);
    blk("R10 slot max", 32'd2, 20'h0, 20'h0, 20'd0, 32'hFFFF_FFFF, 32'd0, BADARG);
    blk("R10 bad code", 32'd7, 20'h0, 20'h0, 20'd0, 32'd0, 32'd0, BADOP);
    blk("R10 bad code high", 32'h8000_0000, 20'h0, 20'h0, 20'd0, 32'd0, 32'd0, BADOP);
    look("R10 no effect", 32'h0050_0000, 0, 0, 0, 0);
    look("R10 block intact", 32'h0010_0000, 1, 32'h8000_0000, 32'h0010_0000, 30'h1FFF_FFFE);

    blk("R12 info status", 32'd0, 20'h0, 20'h0, 20'd0, 32'd0, 32'd0, 32'd0);
    check("R12 info words", blk_info, {32'd2, 32'd0, 32'd16384, 32'd1});

    map_page(32'h0070_0000, 20'h00777, pp_word);
    @(negedge clk);
    blk_valid = 1'b1; blk_code = 32'd0;
    op_valid = 1'b1; op_code = 2'd2; op_addr = 32'h0070_0000;
    @(negedge clk);
    blk_valid = 1'b0; op_valid = 1'b0;
    check("R13 done", {blk_done, blk_status}, {1'b1, 32'd0});
    look("R13 op dropped", 32'h0070_0000, 1, 32'h0077_7000, 32'h0070_0000, 30'h2AAA_5554);

    blk("R9 second block", 32'd1, 20'h00400, 20'h00040, 20'd1, 32'd1, 32'd0, 32'd0);
    look("R9 forced D", 32'h0040_0FFF, 1, 32'h0004_0000, 32'h0040_0000, 30'h1000_0000);
    look("R9 length one", 32'h0040_1000, 0, 0, 0, 0);
    blk("R11 purge one", 32'd2, 20'h0, 20'h0, 20'd0, 32'd1, 32'd0, 32'd0);
    look("R11 slot cleared", 32'h0040_0000, 0, 0, 0, 0);
    look("R11 other block kept", 32'h0010_1000, 1, 32'h8000_0000, 32'h0010_0000, 30'h1FFF_FFFE);
    blk("R11 purge all blocks", 32'd3, 20'h0, 20'h0, 20'd0, 32'd0, 32'd0, 32'd0);
    look("R11 all blocks cleared", 32'h0010_1000, 0, 0, 0, 0);
    look("R11 page kept", 32'h0070_0000, 1, 32'h0077_7000, 32'h0070_0000, 30'h2AAA_5554);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule